// File: doc/BRIEF.md
# Electrically Erasable Byte-Wide Memory Emulator

This block stands in for a small byte-wide nonvolatile memory with classic EPROM-style control pins. The contents live in a parameterized on-chip array (2^AW bytes). A host can read the array, and it can program single bytes. Programming only clears bits: the stored byte becomes its old value ANDed with the new data. The host can also erase the whole array back to FFh, and it can read two fixed identification bytes.

Two digital flags take the place of the high-voltage conditions. `vpp_hi` stands for a raised programming supply, and `a9_hi` stands for a raised level on address bit 9. A program or erase operation is one strobe pulse on `pgm_n`. It only counts if `pgm_n` stays low for a number of clock cycles set by a parameter. A pulse that is released early leaves the memory unchanged. While a pulse is in progress, `busy` is high and the read data is not valid.

Top module: `mtp_byte_mem`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n` = 0 and `oe_n` = 0. In every other combination of those two pins, `dq_oe` is 0.
- R2: With `vpp_hi` = 0, `a9_hi` = 0, `ce_n` = 0, `oe_n` = 0 and `busy` = 0, `dq_out` equals the stored byte at `addr` in the same cycle.
- R3: After reset, every byte reads FFh and `busy` is 0.
- R4: In program mode (`vpp_hi` = 1, `a9_hi` = 0, `ce_n` = 0, `oe_n` = 1), a falling edge on `pgm_n` starts a program pulse. `addr` and `dq_in` are captured at the first clock edge that samples `pgm_n` low. The write completes on the clock edge that samples `pgm_n` low for the PROG_CYC-th consecutive time.
- R5: A completed program stores old AND data. No program ever turns a 0 bit into 1.
- R6: The pulse is aborted and the stored byte is left unchanged if `pgm_n` rises before PROG_CYC low samples, or if the mode pins leave program mode during the pulse.
- R7: In erase mode (`vpp_hi` = 1, `a9_hi` = 1, `ce_n` = 0, `oe_n` = 1), a pulse of ERASE_CYC low samples sets every byte to FFh. The values on `addr` and `dq_in` have no effect.
- R8: With `a9_hi` = 1, `vpp_hi` = 0, `ce_n` = 0 and `oe_n` = 0, `dq_out` is BFh when `addr[0]` = 0 and DEV_ID (default A3h) when `addr[0]` = 1. The other address bits are ignored.
- R9: `busy` goes high after the first clock edge that samples the strobe low in a valid mode. It goes low after the completing edge, or after the edge that detects an abort.
- R10: Holding `pgm_n` low after a pulse completes does not start another operation. A new operation needs the strobe to rise and then fall again.
- R11: A strobe pulse in a mode that is neither program nor erase changes no byte and leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Byte address |
| dq_in | input | 8 | Data bus, inbound half |
| dq_out | output | 8 | Data bus, outbound half |
| dq_oe | output | 1 | Data bus drive enable |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program/erase strobe, active low |
| vpp_hi | input | 1 | Flag: programming supply raised |
| a9_hi | input | 1 | Flag: high level on address bit 9 |
| busy | output | 1 | Program or erase pulse in progress |

## Verification
Read data and identification bytes are combinational, so the bench samples them 1 ns after it changes the inputs, within the same low clock phase. A pulse of N low samples completes on the N-th rising edge after the strobe falls. The bench therefore checks `busy` at the falling edge after each of those rising edges: it expects 1 after edges 1 to N-1 and 0 after edge N. For a short pulse, it expects 0 one edge after the release. Array contents are read back through the normal read path once the pulse has ended. Each read is compared with a bench model that applies the AND and erase rules.

// File: rtl/mtp_pkg.sv
`timescale 1ns/1ps
package mtp_pkg;

    localparam logic [7:0] MFR_ID = 8'hBF;
    localparam logic [7:0] BLANK  = 8'hFF;

    typedef enum logic [2:0] {
        M_OFF,
        M_READ,
        M_IDREAD,
        M_PROG,
        M_ERASE,
        M_OTHER
    } mode_t;

    typedef enum logic [1:0] {
        P_IDLE,
        P_RUN,
        P_HOLD
    } pstate_t;

    function automatic logic [7:0] id_byte(input logic sel, input logic [7:0] dev);
        return sel ? dev : MFR_ID;
    endfunction

endpackage

// File: rtl/mtp_mode_dec.sv
`timescale 1ns/1ps
module mtp_mode_dec
    import mtp_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    input  logic  a9_hi,
    output mode_t mode
);

    always_comb begin
        if (ce_n)
            mode = M_OFF;
        else if (oe_n)
            mode = vpp_hi ? (a9_hi ? M_ERASE : M_PROG) : M_OTHER;
        else
            mode = (a9_hi && !vpp_hi) ? M_IDREAD : M_READ;
    end

endmodule

// File: rtl/mtp_pulse_ctl.sv
`timescale 1ns/1ps
module mtp_pulse_ctl
    import mtp_pkg::*;
#(
    parameter int AW        = 8,
    parameter int PROG_CYC  = 2000,
    parameter int ERASE_CYC = 10_000_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pgm_n,
    input  mode_t         mode,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    data,
    output logic          busy,
    output logic          fire_prog,
    output logic          fire_erase,
    output logic [AW-1:0] lat_addr,
    output logic [7:0]    lat_data
);

    localparam int LONGEST = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYC - 1);

    pstate_t       state;
    logic [CW-1:0] cnt;
    logic          strobe_q;
    logic          op_erase;
    logic          start, same_op, last, fire;

    always_comb begin
        start   = (state == P_IDLE) && !pgm_n && strobe_q &&
                  (mode == M_PROG || mode == M_ERASE);
        same_op = op_erase ? (mode == M_ERASE) : (mode == M_PROG);
        last    = cnt == (op_erase ? ERASE_LAST : PROG_LAST);
        fire    = (state == P_RUN) && !pgm_n && same_op && last;
    end

    assign fire_prog  = fire && !op_erase;
    assign fire_erase = fire && op_erase;
    assign busy       = (state == P_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= P_IDLE;
            cnt      <= '0;
            strobe_q <= 1'b1;
            op_erase <= 1'b0;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            strobe_q <= pgm_n;
            case (state)
                P_IDLE: if (start) begin
                    state    <= P_RUN;
                    cnt      <= CW'(1);
                    op_erase <= (mode == M_ERASE);
                    lat_addr <= addr;
                    lat_data <= data;
                end
                P_RUN: begin
                    if (pgm_n || !same_op)
                        state <= P_IDLE;
                    else if (last)
                        state <= P_HOLD;
                    else
                        cnt <= cnt + CW'(1);
                end
                P_HOLD: if (pgm_n) state <= P_IDLE;
                default: state <= P_IDLE;
            endcase
        end
    end

    initial begin
        assert (PROG_CYC >= 2 && ERASE_CYC >= 2)
            else $error("pulse lengths must be at least 2 cycles");
    end

    // R9: busy only ever follows a low strobe sample
    assert_busy_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> $past(!pgm_n));

    // R4: the pulse counter never runs past the longest pulse
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= CW'(LONGEST - 1)));

endmodule

// File: rtl/mtp_cell_array.sv
`timescale 1ns/1ps
module mtp_cell_array
    import mtp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_we,
    input  logic          erase_we,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || erase_we) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
        end else if (prog_we) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R5: without an erase, no bit of the watched byte goes from 0 to 1
    assert_no_set_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(erase_we) && $stable(rd_addr))
            |-> ((rd_data & ~$past(rd_data)) == 8'h00));

    // R7: after an erase edge any byte reads blank
    assert_erase_blank_R7: assert property (@(posedge clk) disable iff (rst)
        $past(erase_we) |-> (rd_data == BLANK));

endmodule

// File: rtl/mtp_byte_mem.sv
`timescale 1ns/1ps
module mtp_byte_mem
    import mtp_pkg::*;
#(
    parameter int         AW        = 8,
    parameter int         PROG_CYC  = 2000,
    parameter int         ERASE_CYC = 10_000_000,
    parameter logic [7:0] DEV_ID    = 8'hA3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_in,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          pgm_n,
    input  logic          vpp_hi,
    input  logic          a9_hi,
    output logic          busy
);

    mode_t         mode;
    logic          fire_prog, fire_erase;
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_data;
    logic [7:0]    rd_data;

    mtp_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .a9_hi  (a9_hi),
        .mode   (mode)
    );

    mtp_pulse_ctl #(
        .AW        (AW),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .pgm_n      (pgm_n),
        .mode       (mode),
        .addr       (addr),
        .data       (dq_in),
        .busy       (busy),
        .fire_prog  (fire_prog),
        .fire_erase (fire_erase),
        .lat_addr   (lat_addr),
        .lat_data   (lat_data)
    );

    mtp_cell_array #(.AW(AW)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .prog_we  (fire_prog),
        .erase_we (fire_erase),
        .wr_addr  (lat_addr),
        .wr_data  (lat_data),
        .rd_addr  (addr),
        .rd_data  (rd_data)
    );

    assign dq_oe  = !ce_n && !oe_n;
    assign dq_out = busy ? 8'h00 :
                    (mode == M_IDREAD) ? id_byte(addr[0], DEV_ID) : rd_data;

    // R4: a pulse only begins with chip enabled, outputs off and supply raised
    assert_entry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!ce_n && oe_n && vpp_hi));

    // R8: identification read of the even address yields the maker byte
    assert_id_mfr_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ce_n && !oe_n && a9_hi && !vpp_hi && !addr[0])
            |-> (dq_out == MFR_ID));

endmodule

// File: tb/mtp_byte_mem_test.sv
`timescale 1ns/1ps
module mtp_byte_mem_test;

    localparam int         AW    = 4;
    localparam int         DEPTH = 1 << AW;
    localparam int         PCYC  = 5;
    localparam int         ECYC  = 12;
    localparam logic [7:0] DEV   = 8'h5C;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [7:0]    dq_in, dq_out;
    logic          dq_oe, ce_n, oe_n, pgm_n, vpp_hi, a9_hi, busy;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    mtp_byte_mem #(
        .AW(AW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC), .DEV_ID(DEV)
    ) uut (
        .clk(clk), .rst(rst), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .a9_hi(a9_hi), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go_read();
        @(negedge clk);
        vpp_hi = 0; a9_hi = 0; ce_n = 0; oe_n = 0; pgm_n = 1;
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        addr = AW'(a);
        #1;
        chk(dq_out == exp && dq_oe, tag, dq_out, exp);
    endtask

    task automatic strobe(input logic vpp, input logic a9, input int a,
                          input logic [7:0] d, input int nlow, input int len,
                          input bit valid, input string tag);
        @(negedge clk);
        vpp_hi = vpp; a9_hi = a9; ce_n = 0; oe_n = 1; pgm_n = 1;
        addr = AW'(a); dq_in = d;
        @(negedge clk);
        pgm_n = 0;
        for (int k = 1; k <= nlow; k++) begin
            @(negedge clk);
            chk(busy == (valid && (nlow < len || k < len)), tag, busy,
                valid && (nlow < len || k < len));
        end
        pgm_n = 1;
        @(negedge clk);
        chk(busy == 1'b0, tag, busy, 0);
        go_read();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; addr = '0; dq_in = '0; ce_n = 1; oe_n = 1; pgm_n = 1;
        vpp_hi = 0; a9_hi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

        // R3: blank after reset, idle
        go_read();
        chk(busy == 1'b0, "R3 busy", busy, 0);
        for (int a = 0; a < DEPTH; a++) rd(a, 8'hFF, "R3 blank");

        // R1: all four enable combinations
        for (int c = 0; c < 4; c++) begin
            ce_n = c[0]; oe_n = c[1];
            #1;
            chk(dq_oe == (c == 0), "R1 drive", dq_oe, c == 0);
        end

        // R4 R9 R2: program every address with a first pattern
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] d = 8'(a * 29 + 7);
            strobe(1, 0, a, d, PCYC, PCYC, 1, "R9 busy prog");
            model[a] = model[a] & d;
        end
        for (int a = 0; a < DEPTH; a++) rd(a, model[a], "R4 R2 prog read");

        // R5: second pattern only clears bits
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] d = 8'(~(a << 3)) ^ 8'h5A;
            strobe(1, 0, a, d, PCYC, PCYC, 1, "R9 busy prog2");
            model[a] = model[a] & d;
        end
        for (int a = 0; a < DEPTH; a++) rd(a, model[a], "R5 and-only");

        // R6: short pulses leave the byte alone
        strobe(1, 0, 3, 8'h00, PCYC - 1, PCYC, 1, "R6 busy short");
        rd(3, model[3], "R6 early release");
        strobe(1, 0, 4, 8'h00, 1, PCYC, 1, "R6 busy one");
        rd(4, model[4], "R6 one sample");

        // R10: strobe held long completes once and busy stays low
        strobe(1, 0, 5, 8'h0F, PCYC + 4, PCYC, 1, "R10 busy hold");
        model[5] = model[5] & 8'h0F;
        rd(5, model[5], "R10 single op");

        // R11: strobe with the supply flag low does nothing
        strobe(0, 0, 6, 8'h00, PCYC + 1, PCYC, 0, "R11 busy");
        rd(6, model[6], "R11 unchanged");

        // R8: identification bytes across every address
        @(negedge clk);
        a9_hi = 1;
        for (int a = 0; a < DEPTH; a++)
            rd(a, a[0] ? DEV : 8'hBF, "R8 id");
        go_read();

        // R6: erase-length pulse too short keeps data
        strobe(1, 1, 9, 8'h00, ECYC - 1, ECYC, 1, "R6 busy erase short");
        for (int a = 0; a < DEPTH; a++) rd(a, model[a], "R6 erase aborted");

        // R7: full erase with arbitrary addr/data
        strobe(1, 1, 11, 8'h3C, ECYC, ECYC, 1, "R7 busy erase");
        for (int a = 0; a < DEPTH; a++) rd(a, 8'hFF, "R7 erased");

        // R4: reprogram after erase
        strobe(1, 0, 2, 8'hA5, PCYC, PCYC, 1, "R4 busy again");
        rd(2, 8'hA5, "R4 after erase");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule